// File: doc/BRIEF.md
# Push-Button Symbol Event Encoder

This block takes three active-low push buttons, each wired to a raw and asynchronous input, and turns them into clean single-cycle symbol events for a downstream sequence recogniser. Each raw line first goes through a two-flop synchronizer. The synchronized vector must then hold one value for a programmable number of cycles before the block accepts it as the new settled pattern. The block watches for the settled pattern to move from "no button down" to exactly one button down. When that happens it raises a one-cycle strobe and drives the symbol code for that button.

The block emits one event for each physical press, however long the key stays down. A release emits nothing. A pattern with two or three keys down emits nothing. A move from one key straight to another key, with no idle pattern in between, also emits nothing. A downstream state machine fed from this block therefore moves at most one step per press, even with a clock far faster than a human hand.

Top module: `btn_symbol_encoder`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls with all buttons released, `sym_valid` is 0 and `sym_code` is 2'b10. The settled pattern returns to idle (3'b111), so reset never produces an event.
- R2: A new settled pattern takes effect only after a fixed delay. If a single-button pattern is applied just before clock edge 1 and then held, `sym_valid` is 0 after edge DEBOUNCE_CYCLES+3 and is 1 after edge DEBOUNCE_CYCLES+4.
- R3: A settled single-button pattern produces one of three codes: 3'b110 gives 2'b00, 3'b101 gives 2'b01, and 3'b011 gives 2'b11. Bit i of `btn_n` is button i, and a 0 means pressed.
- R4: `sym_valid` stays high for exactly one cycle, and a press that is held produces exactly one event.
- R5: A return of the buttons to 3'b111 produces no event.
- R6: A settled pattern with more than one button pressed produces no event.
- R7: A change on the buttons that lasts fewer than DEBOUNCE_CYCLES cycles does not alter the settled pattern. A bouncing press that then settles produces exactly one event.
- R8: A change from one single-button pattern straight to another, with no idle pattern between them, produces no event.
- R9: Whenever `sym_valid` is 0, `sym_code` is 2'b10. Code 2'b10 is never driven while `sym_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_n | input | 3 | Raw button lines, active low, asynchronous |
| sym_valid | output | 1 | One-cycle event strobe |
| sym_code | output | 2 | Symbol code; 2'b10 when no event |

## Verification
The event arrives after a fixed pipeline: two synchronizer edges, one edge to capture the candidate pattern, DEBOUNCE_CYCLES edges of qualification, and one edge to register the strobe. It therefore appears DEBOUNCE_CYCLES+4 edges after a clean input change. The bench applies stimulus on a falling edge, counts rising edges, and samples on the next falling edge. It checks the strobe is still 0 one edge early and is 1 with the right code exactly on time. The bench also counts every strobe that appears. This count covers long holds, releases, multi-button patterns, bounces and key-to-key changes, which are checked over windows that are several times longer than the pipeline.

// File: rtl/btn_symbol_pkg.sv
package btn_symbol_pkg;

    localparam int NUM_BTN = 3;
    localparam logic [NUM_BTN-1:0] BTN_IDLE = '1;

    typedef enum logic [1:0] {
        SYM_A    = 2'b00,
        SYM_B    = 2'b01,
        SYM_NONE = 2'b10,
        SYM_C    = 2'b11
    } sym_e;

    // True when exactly one active-low line is pulled down.
    function automatic logic one_pressed(input logic [NUM_BTN-1:0] v);
        return $countones(~v) == 1;
    endfunction

    function automatic sym_e encode(input logic [NUM_BTN-1:0] v);
        sym_e s;
        case (v)
            3'b110:  s = SYM_A;
            3'b101:  s = SYM_B;
            3'b011:  s = SYM_C;
            default: s = SYM_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
            end else begin
                meta_q <= raw_i[i];
                sync_q <= meta_q;
            end
        end
        assign sync_o[i] = sync_q;
    end
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
    parameter int W      = 3,
    parameter int CYCLES = 50000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sync_i,
    output logic [W-1:0] stable_o
);
    localparam int          CW   = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [W-1:0]  cand_q, stable_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q   <= '1;
            stable_q <= '1;
            cnt_q    <= '0;
        end else if (sync_i != cand_q) begin
            cand_q <= sync_i;
            cnt_q  <= '0;
        end else if (cand_q != stable_q) begin
            if (cnt_q == LAST) begin
                stable_q <= cand_q;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign stable_o = stable_q;

    // Settled value may only move after a full qualification window.
    assert_settle_window_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(stable_q) |-> ($past(cnt_q) == LAST && $past(cand_q) == stable_q));
endmodule

// File: rtl/btn_press_detect.sv
module btn_press_detect
    import btn_symbol_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_BTN-1:0] stable_i,
    output logic               valid_o,
    output sym_e               code_o
);
    logic [NUM_BTN-1:0] prev_q;
    logic               valid_q;
    sym_e               code_q;
    logic               fire;

    assign fire = (stable_i != prev_q) && (prev_q == BTN_IDLE) && one_pressed(stable_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= BTN_IDLE;
            valid_q <= 1'b0;
            code_q  <= SYM_NONE;
        end else begin
            prev_q  <= stable_i;
            valid_q <= fire;
            code_q  <= fire ? encode(stable_i) : SYM_NONE;
        end
    end

    assign valid_o = valid_q;
    assign code_o  = code_q;

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);
    assert_event_single_key_R6: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> one_pressed(prev_q));
    assert_prior_idle_R8: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> $past(prev_q) == BTN_IDLE);
endmodule

// File: rtl/btn_symbol_encoder.sv
module btn_symbol_encoder
    import btn_symbol_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 50000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] btn_n,
    output logic       sym_valid,
    output logic [1:0] sym_code
);
    logic [NUM_BTN-1:0] sync_v, stable_v;
    sym_e               code;

    btn_sync #(.W(NUM_BTN)) u_sync (
        .clk(clk), .rst(rst), .raw_i(btn_n), .sync_o(sync_v)
    );

    btn_debounce #(.W(NUM_BTN), .CYCLES(DEBOUNCE_CYCLES)) u_deb (
        .clk(clk), .rst(rst), .sync_i(sync_v), .stable_o(stable_v)
    );

    btn_press_detect u_det (
        .clk(clk), .rst(rst), .stable_i(stable_v), .valid_o(sym_valid), .code_o(code)
    );

    assign sym_code = code;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !sym_valid);
    assert_code_reserved_R9: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> sym_code != 2'b10);
    assert_idle_code_R9: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |-> sym_code == 2'b10);
endmodule

// File: tb/test_btn_symbol_encoder.sv
module test_btn_symbol_encoder;
    localparam int CLK_PERIOD = 20;
    localparam int DEB        = 4;
    localparam int LAT        = DEB + 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] btn_n = 3'b111;
    logic       sym_valid;
    logic [1:0] sym_code;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    bit done   = 0;

    btn_symbol_encoder #(.DEBOUNCE_CYCLES(DEB)) i_btn_symbol_encoder (
        .clk(clk), .rst(rst), .btn_n(btn_n), .sym_valid(sym_valid), .sym_code(sym_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (!rst && sym_valid) pulses++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic report;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Apply pattern p from idle and check timing, code, hold and release.
    task automatic sweep(input logic [2:0] p);
        int low, idx, exp_ev, exp_code, base;
        low = 0; idx = 0;
        for (int i = 0; i < 3; i++) if (!p[i]) begin low++; idx = i; end
        exp_ev   = (low == 1) ? 1 : 0;
        exp_code = exp_ev ? ((idx == 0) ? 0 : (idx == 1) ? 1 : 3) : 2;
        base = pulses;
        btn_n = p;
        edges(LAT - 1);
        check("R2 early", int'(sym_valid), 0);
        edges(1);
        check(exp_ev ? "R2 on time" : "R6 multi", int'(sym_valid), exp_ev);
        check(exp_ev ? "R3 code" : "R9 code", int'(sym_code), exp_code);
        edges(1);
        check("R4 strobe width", int'(sym_valid), 0);
        edges(60);
        check("R4 held press", pulses - base, exp_ev);
        base = pulses;
        btn_n = 3'b111;
        edges(3 * LAT);
        check("R5 release", pulses - base, 0);
        check("R9 idle code", int'(sym_code), 2);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int base;
        edges(3);
        check("R1 valid in reset", int'(sym_valid), 0);
        check("R1 code in reset", int'(sym_code), 2);
        rst = 1'b0;
        edges(1);
        check("R1 valid after reset", int'(sym_valid), 0);
        check("R1 code after reset", int'(sym_code), 2);
        edges(2 * LAT);
        check("R1 no event after reset", pulses, 0);

        for (int p = 0; p < 7; p++) sweep(p[2:0]);

        // R7: short glitches are ignored
        base = pulses;
        for (int k = 0; k < 5; k++) begin
            btn_n = 3'b101; edges(DEB - 2);
            btn_n = 3'b111; edges(DEB - 2);
        end
        edges(3 * LAT);
        check("R7 glitch", pulses - base, 0);

        // R7: bouncing press then settle gives one event
        base = pulses;
        for (int k = 0; k < 4; k++) begin
            btn_n = 3'b110; edges(2);
            btn_n = 3'b111; edges(1);
        end
        btn_n = 3'b110;
        edges(4 * LAT);
        check("R7 bounce one event", pulses - base, 1);

        // R8: key-to-key change without idle
        base = pulses;
        btn_n = 3'b011;
        edges(4 * LAT);
        check("R8 key change", pulses - base, 0);
        btn_n = 3'b111;
        edges(3 * LAT);

        // R1: reset while a key is held, released with keys idle
        btn_n = 3'b101;
        edges(3 * LAT);
        base = pulses;
        rst = 1'b1;
        btn_n = 3'b111;
        edges(1);
        check("R1 valid under reset", int'(sym_valid), 0);
        edges(3);
        rst = 1'b0;
        edges(3 * LAT);
        check("R1 no event at release", pulses - base, 0);

        report();
    end
endmodule